// File: doc/BRIEF.md
# Sticky Status Word with Read-and-Release

This block keeps a 16-bit status word for a byte-oriented serial command port. The low part of the word is live state that follows its inputs every cycle. The upper part is a set of failure flags. Each flag latches on a one-cycle alarm pulse, so a transient fault stays visible. One of those flags records a command that was wrong or could not be performed, and the command engine raises it.

Every byte the port completes is presented once on `rx_valid`, together with a marker that says whether it is a command byte or an argument byte. Two command bytes read the word. The plain register read is the read opcode carrying the status address. The dedicated get-status opcode also releases the flags. Both capture the word on the cycle the command byte is decoded. The captured word then goes out over the next two byte exchanges, most significant byte first. `tx_byte` is 00h when no response is pending. `flag_n` is an open-drain style summary that sits low while any failure flag is set.

Top module: `status_latch`

## Requirements
- R1: After reset every failure flag is clear, `flag_n` is high, `tx_byte` is 00h and `status_word` shows only `live_i`.
- R2: A one-cycle pulse on a bit of `alarm_i` sets flag bit `8+i` of `status_word` from the next cycle. The flag stays set until it is released, however many cycles pass.
- R3: A one-cycle pulse on `cmd_fault_i` sets bit 15 of `status_word` from the next cycle, and that bit is sticky like the others.
- R4: The command byte D0h (with `rx_is_cmd`=1) loads a response. `tx_byte` shows the high byte after that exchange, the low byte after the next exchange, and 00h after the one after that.
- R5: The word sent back by D0h is the word as it stood before the release, so it still contains every flag that was set.
- R6: All failure flags are released on the cycle the D0h command byte is decoded. They show as clear in `status_word` right after that byte, before any response byte has gone out.
- R7: The plain read byte 39h (opcode bits 7:5 = 001, address bits 4:0 = 19h) returns the same two-byte word and leaves every flag set.
- R8: An alarm pulse in the same cycle as a D0h release leaves its flag set afterwards.
- R9: A status command that arrives before a response has finished discards the rest of the old response, and the new response starts at its high byte.
- R10: `flag_n` is low exactly while at least one failure flag (bits 15:8) is set.
- R11: A byte equal to D0h or 39h that is marked as an argument (`rx_is_cmd`=0) is not decoded. The flags are kept, and the response moves on by one byte.
- R12: Live bits 7:0 are not latched. The response holds the value captured at decode time, even if `live_i` changes later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a byte exchange has completed |
| rx_is_cmd | input | 1 | The completed byte is a command byte, not an argument |
| rx_byte | input | 8 | Byte received in the completed exchange |
| live_i | input | 8 | Live state bits, bits 7:0 of the word |
| alarm_i | input | 7 | Alarm pulses for the flags at bits 14:8 |
| cmd_fault_i | input | 1 | Wrong or unperformable command pulse, flag at bit 15 |
| tx_byte | output | 8 | Byte to send in the next exchange |
| status_word | output | 16 | Current status word |
| flag_n | output | 1 | Low while any failure flag is set |

## Verification
The two reading commands are each issued with flags set, with flags clear, with an alarm pulse in the same cycle as the release, and with the live bits changing while a response is going out. Comparing these cases shows which command releases the flags and when. It also shows whether the response is a snapshot or follows the live value, and whether a pulse at the moment of release survives. Back-to-back status commands show whether a new response replaces the old one. The opcode values sent as argument bytes show that decoding depends on the command marker and not on the byte value alone.

// File: rtl/stflag_pkg.sv
package stflag_pkg;
    // Command byte that returns the word and releases the flags
    localparam logic [7:0] GETSTAT_OPC = 8'hD0;
    // Upper three bits of a generic register-read command byte
    localparam logic [2:0] RDREG_PFX   = 3'b001;
    // Default register address of the status word
    localparam logic [4:0] STAT_ADDR_DEF = 5'h19;
endpackage

// File: rtl/sflag_bank.sv
module sflag_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] flags_o
);
    typedef struct packed {
        logic [N-1:0] flags;
    } bank_t;

    bank_t        st_d, st_q;
    logic [N-1:0] nxt;

    // set has priority over a release in the same cycle
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign nxt[i] = set_i[i] | (st_q.flags[i] & ~clr_i);
    end

    always_comb begin
        st_d       = st_q;
        st_d.flags = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;

    // R2: with no release, no flag ever drops
    p_sticky_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((flags_o & $past(flags_o)) == $past(flags_o)));
    // R8: a pulse always lands, even during a release
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((flags_o & $past(set_i)) == $past(set_i)));
    // R6: a release without pulses empties the bank
    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && set_i == '0) |=> (flags_o == '0));
endmodule

// File: rtl/scmd_decode.sv
module scmd_decode
    import stflag_pkg::*;
#(
    parameter logic [4:0] STAT_ADDR = STAT_ADDR_DEF
) (
    input  logic       rx_valid,
    input  logic       rx_is_cmd,
    input  logic [7:0] rx_byte,
    output logic       get_stat_o,
    output logic       plain_rd_o
);
    logic cmd_ok;

    always_comb begin
        cmd_ok     = rx_valid & rx_is_cmd;
        get_stat_o = cmd_ok & (rx_byte == GETSTAT_OPC);
        plain_rd_o = cmd_ok & (rx_byte[7:5] == RDREG_PFX) & (rx_byte[4:0] == STAT_ADDR);
    end
endmodule

// File: rtl/sresp_shift.sv
module sresp_shift #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [7:0]        tx_o
);
    localparam int BYTES = WORD_W / 8;
    localparam int CW    = $clog2(BYTES + 1);

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [CW-1:0]     left;
    } resp_t;

    resp_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step_i) begin
            if (load_i) begin
                st_d.data = word_i;
                st_d.left = CW'(BYTES);
            end else if (st_q.left != '0) begin
                st_d.data = st_q.data << 8;
                st_d.left = st_q.left - CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_o = (st_q.left != '0) ? st_q.data[WORD_W-1 -: 8] : 8'h00;

    // R4: a load presents the high byte of the captured word next
    p_load_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (tx_o == $past(word_i[WORD_W-1 -: 8])));
    // R4: when nothing is pending, a plain exchange returns 00h
    p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && tx_o == 8'h00 && st_q.left == '0) |=> (tx_o == 8'h00));
    // R12: without an exchange the outgoing byte holds
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(tx_o));
endmodule

// File: rtl/status_latch.sv
module status_latch
    import stflag_pkg::*;
#(
    parameter int         LIVE_W    = 8,
    parameter int         ALARM_W   = 7,
    parameter logic [4:0] STAT_ADDR = STAT_ADDR_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_valid,
    input  logic                rx_is_cmd,
    input  logic [7:0]          rx_byte,
    input  logic [LIVE_W-1:0]   live_i,
    input  logic [ALARM_W-1:0]  alarm_i,
    input  logic                cmd_fault_i,
    output logic [7:0]          tx_byte,
    output logic [LIVE_W+ALARM_W:0] status_word,
    output logic                flag_n
);
    localparam int FLAG_W = ALARM_W + 1;
    localparam int WORD_W = LIVE_W + FLAG_W;

    logic              get_stat, plain_rd;
    logic [FLAG_W-1:0] flag_set, flags;
    logic [WORD_W-1:0] word_now;

    scmd_decode #(.STAT_ADDR(STAT_ADDR)) u_dec (
        .rx_valid   (rx_valid),
        .rx_is_cmd  (rx_is_cmd),
        .rx_byte    (rx_byte),
        .get_stat_o (get_stat),
        .plain_rd_o (plain_rd)
    );

    // command-engine fault sits at the top bit of the word
    assign flag_set = {cmd_fault_i, alarm_i};

    sflag_bank #(.N(FLAG_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (flag_set),
        .clr_i   (get_stat),
        .flags_o (flags)
    );

    // word as it stands before this cycle's release
    assign word_now = {flags, live_i};

    sresp_shift #(.WORD_W(WORD_W)) u_resp (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (rx_valid),
        .load_i (get_stat | plain_rd),
        .word_i (word_now),
        .tx_o   (tx_byte)
    );

    assign status_word = word_now;
    assign flag_n      = ~|flags;

    // R10: summary pin tracks the flag field of the word
    p_flag_pin_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flag_n == (status_word[WORD_W-1:LIVE_W] == '0));
    // R6: get-status with no pulses leaves the flag field empty
    p_getstat_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_is_cmd && rx_byte == GETSTAT_OPC && !cmd_fault_i && alarm_i == '0)
        |=> (status_word[WORD_W-1:LIVE_W] == '0));
    // R7: a plain read keeps every flag
    p_plain_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        plain_rd |=> ((flags & $past(flags)) == $past(flags)));
    // R11: argument bytes never release flags
    p_arg_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_is_cmd) |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: tb/status_latch_bench.sv
module status_latch_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic        rx_is_cmd = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic [7:0]  live_i = 8'h00;
    logic [6:0]  alarm_i = 7'h00;
    logic        cmd_fault_i = 1'b0;
    logic [7:0]  tx_byte;
    logic [15:0] status_word;
    logic        flag_n;

    always #4 clk = ~clk;  // 125 MHz

    status_latch u_status_latch (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_is_cmd(rx_is_cmd),
        .rx_byte(rx_byte), .live_i(live_i), .alarm_i(alarm_i),
        .cmd_fault_i(cmd_fault_i), .tx_byte(tx_byte),
        .status_word(status_word), .flag_n(flag_n)
    );

    typedef struct { logic [7:0] exp; string tag; } item_t;
    item_t sb_q[$];
    event  sampled;
    int    n_checks = 0;
    int    n_err = 0;
    bit    done = 1'b0;

    // independent model built from the requirements
    logic [15:0] m_sticky = 16'h0;
    logic [15:0] m_resp = 16'h0;
    int          m_left = 0;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word();
        return m_sticky | {8'h00, live_i};
    endfunction

    // monitor: pops the expected outgoing byte after each exchange
    initial begin
        forever begin
            @(sampled);
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                check(it.tag, {8'h00, tx_byte}, {8'h00, it.exp});
            end
        end
    end

    // driver: one byte exchange, optionally with simultaneous pulses
    task automatic xfer(input logic [7:0] b, input bit is_cmd,
                        input logic [6:0] al, input bit cf, input string tag);
        logic [15:0] snap;
        item_t it;
        snap = exp_word();
        if (is_cmd && b == 8'hD0) begin
            m_resp = snap; m_left = 2; m_sticky = 16'h0;
        end else if (is_cmd && b == 8'h39) begin
            m_resp = snap; m_left = 2;
        end else if (m_left > 0) begin
            m_resp = m_resp << 8; m_left--;
        end
        m_sticky = m_sticky | {cf, al, 8'h00};
        it.exp = (m_left > 0) ? m_resp[15:8] : 8'h00;
        it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        rx_valid = 1'b1; rx_is_cmd = is_cmd; rx_byte = b;
        alarm_i = al; cmd_fault_i = cf;
        @(negedge clk);
        rx_valid = 1'b0; rx_is_cmd = 1'b0; rx_byte = 8'h00;
        alarm_i = 7'h00; cmd_fault_i = 1'b0;
        -> sampled;
        @(negedge clk);
    endtask

    task automatic pulse(input logic [6:0] al, input bit cf);
        @(negedge clk);
        alarm_i = al; cmd_fault_i = cf;
        @(negedge clk);
        alarm_i = 7'h00; cmd_fault_i = 1'b0;
        m_sticky = m_sticky | {cf, al, 8'h00};
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_checks++; n_err++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 tx", {8'h00, tx_byte}, 16'h0000);
        check("R1 flag_n", {15'h0, flag_n}, 16'h0001);
        check("R1 word", status_word, 16'h0000);

        // R12: live bits pass straight through
        live_i = 8'hA5;
        @(negedge clk);
        check("R12 live", status_word, exp_word());

        // R2 / R10: alarm bit 2 latches as word bit 10
        pulse(7'b0000100, 1'b0);
        check("R2 set", status_word, 16'h04A5);
        check("R10 low", {15'h0, flag_n}, 16'h0000);
        repeat (20) @(negedge clk);
        check("R2 hold", status_word, 16'h04A5);

        // R3: command fault goes to bit 15
        pulse(7'h00, 1'b1);
        check("R3 fault", status_word, 16'h84A5);

        // R7: plain read, flags kept
        xfer(8'h39, 1'b1, 7'h00, 1'b0, "R7 high");
        check("R7 kept", status_word, 16'h84A5);
        xfer(8'h00, 1'b1, 7'h00, 1'b0, "R7 low");
        xfer(8'h00, 1'b1, 7'h00, 1'b0, "R4 idle");

        // R5 / R6 / R12: get-status captures then releases
        xfer(8'hD0, 1'b1, 7'h00, 1'b0, "R5 high");
        check("R6 released", status_word, 16'h00A5);
        check("R10 high", {15'h0, flag_n}, 16'h0001);
        live_i = 8'h3C;
        xfer(8'h00, 1'b1, 7'h00, 1'b0, "R12 low snap");
        xfer(8'h00, 1'b1, 7'h00, 1'b0, "R4 trailing");

        // R8: pulse in the release cycle survives
        pulse(7'b1000000, 1'b0);
        xfer(8'hD0, 1'b1, 7'b0000001, 1'b0, "R8 high");
        check("R8 kept", status_word, 16'h013C);
        xfer(8'h00, 1'b1, 7'h00, 1'b0, "R8 low");
        xfer(8'h00, 1'b1, 7'h00, 1'b0, "R4 idle2");

        // R11: opcodes as argument bytes are not decoded
        xfer(8'hD0, 1'b0, 7'h00, 1'b0, "R11 arg d0");
        check("R11 flags", status_word, 16'h013C);
        xfer(8'h39, 1'b0, 7'h00, 1'b0, "R11 arg 39");

        // R9: new command replaces a half-sent response
        pulse(7'h00, 1'b1);
        xfer(8'h39, 1'b1, 7'h00, 1'b0, "R9 first");
        live_i = 8'h5A;
        xfer(8'hD0, 1'b1, 7'h00, 1'b0, "R9 replace");
        xfer(8'h00, 1'b1, 7'h00, 1'b0, "R9 low");
        xfer(8'h00, 1'b1, 7'h00, 1'b0, "R9 idle");
        check("R9 cleared", status_word, 16'h005A);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule